// File: doc/BRIEF.md
# Multi-Device Oscillator SPI Update Controller

This block is the serial master for a group of external digitally controlled crystal oscillators. Each oscillator has its own chip-select and serial clock line. All oscillators share one master-out data line and one master-in data line. The block serves two clients. The first is a CPU command port, used for reset, single-register write, single-register read, and loading a per-device base divider word. The second is a stream from the clock-recovery loop filter, which carries a port index and a signed correction value. The CPU sets up each oscillator once. After that, every correction value from the filter becomes a divider-word write to the matching oscillator, with no software involved.

The filter stream is valid/ready. The block keeps one pending slot per port, and a newer value replaces one that has not yet been sent. For that reason `flt_ready` is high in every cycle outside reset, and the stream never sees back-pressure. An update is taken in any cycle where `flt_valid` and `flt_ready` are both high. A CPU request is a one-cycle pulse. CPU accesses win arbitration, but only once the transaction on the wire has finished.

Top module: `dcxo_spi_ctrl`

## Requirements
- R1: After reset, every `spi_cs_n` bit is 1, every `spi_sck` bit is 0, `spi_mosi` is 0, `cpu_busy` is 0 and `cpu_rd_done` is 0.
- R2: During a transaction, only the addressed device has `spi_cs_n` low and only its `spi_sck` toggles. At most one `spi_cs_n` bit is ever low, and a `spi_sck` bit is never high while its own `spi_cs_n` is high.
- R3: The serial timing is SPI mode 0. The clock idles low and data goes out MSB first. `spi_mosi` does not change on a rising clock edge. Each high phase and each low phase of `spi_sck` lasts `clk_div`+1 clock cycles.
- R4: `cpu_op`=0 (write) sends a 16-bit frame: bit 15 is 0, bits 14:8 are `cpu_addr`, and bits 7:0 are `cpu_wdata[7:0]`.
- R5: `cpu_op`=1 (read) sends a 16-bit frame: bit 15 is 1, bits 14:8 are the address, and bits 7:0 are 0. The block samples `spi_miso` on rising clock edges 9 to 16, MSB first, into `cpu_rd_data`. At the end of the frame it sets `cpu_rd_done` to 1.
- R6: `cpu_op`=2 (device reset) sends the 16-bit frame {0, 7'h7F, 8'h01}.
- R7: `cpu_busy` goes high in the cycle after a request is accepted and stays high until that frame ends. A `cpu_req` that arrives while `cpu_busy` is high is ignored and produces no frame.
- R8: `cpu_op`=3 loads `cpu_wdata` as the base divider word of device `cpu_dev`. It is accepted in any cycle, sends no frame and does not raise `cpu_busy`.
- R9: `flt_ready` is 1 whenever reset is low. Each accepted update sends a 40-bit frame to device `flt_port`: {0, 7'h10, W}. W is the device's base word plus the sign-extended `flt_value`, taken modulo 2^32 and sent MSB first.
- R10: A second update to a port whose earlier value has not been sent replaces that value. Only the newest value is sent, and it is sent once.
- R11: A frame on the wire is never cut short. When it ends, a pending CPU access is sent before any pending filter update.
- R12: Pending filter ports are served round-robin. The scan starts at the port after the one served last, and from reset the scan starts at port 0.
- R13: `cpu_rd_done` returns to 0 in the cycle after a new CPU request (ops 0–2) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_div | input | DIV_W | Serial clock half-period minus one, in clk cycles |
| cpu_req | input | 1 | One-cycle CPU request strobe |
| cpu_op | input | 2 | 0 write, 1 read, 2 device reset, 3 load base word |
| cpu_dev | input | DEV_W | Target device |
| cpu_addr | input | 7 | Device register address |
| cpu_wdata | input | WORD_W | Write byte in bits 7:0, or the full base word |
| cpu_busy | output | 1 | A CPU access is pending or on the wire |
| cpu_rd_data | output | 8 | Last byte read |
| cpu_rd_done | output | 1 | Read data is valid |
| flt_valid | input | 1 | Filter update valid |
| flt_ready | output | 1 | Filter update accepted (high outside reset) |
| flt_port | input | DEV_W | Port / device index of the update |
| flt_value | input | CTRL_W | Signed correction value |
| spi_sck | output | NUM_DEV | Serial clock, one per device |
| spi_cs_n | output | NUM_DEV | Chip-select, active low, one per device |
| spi_mosi | output | 1 | Shared serial data to the devices |
| spi_miso | input | 1 | Shared serial data from the devices |

## Verification
The bench goes after the cases where arbitration and buffering interact. It sends two updates to the same port while the wire is busy; a design without overwrite would send both frames or the stale value. It raises a CPU request while a 40-bit update is mid-frame; a design that preempts would truncate that frame, and one that puts filter traffic first would send the CPU write last. It sweeps corrections across the signed limits and past the 32-bit wrap, where a missing sign extension gives a wrong high word. It checks the round-robin order after a known last-served port, sampling on the rising edge where the read byte is captured and changing the half-period, so that an off-by-one divider or edge choice shows up as a wrong byte or a wrong phase length.

// File: rtl/dcxo_spi_pkg.sv
package dcxo_spi_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_RESET = 2'd2,
    OP_BASE  = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_frame_engine.sv
// Bit-level SPI mode 0 master: shifts one left-aligned frame to one device.
module spi_frame_engine
  import dcxo_spi_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2,
  parameter int FRAME_W = 40,
  parameter int CNT_W   = 6,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DEV_W-1:0]   start_dev,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic [CNT_W-1:0]   start_bits,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               miso_i,
  output logic               busy,
  output logic               done,
  output logic [7:0]         rx_byte,
  output logic [NUM_DEV-1:0] sck_o,
  output logic [NUM_DEV-1:0] cs_n_o,
  output logic               mosi_o
);
  eng_state_e         state_q;
  logic [DEV_W-1:0]   dev_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   bits_left_q;
  logic [DIV_W-1:0]   half_cnt_q;
  logic               sck_q;
  logic [7:0]         rx_q;
  logic               tick;

  assign tick = (half_cnt_q == clk_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ENG_IDLE;
      dev_q       <= '0;
      shreg_q     <= '0;
      bits_left_q <= '0;
      half_cnt_q  <= '0;
      sck_q       <= 1'b0;
      rx_q        <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (start) begin
            state_q     <= ENG_SHIFT;
            dev_q       <= start_dev;
            shreg_q     <= start_frame;
            bits_left_q <= start_bits;
            half_cnt_q  <= '0;
            sck_q       <= 1'b0;
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            half_cnt_q <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_q  <= {rx_q[6:0], miso_i};
            end else begin
              sck_q       <= 1'b0;
              bits_left_q <= bits_left_q - CNT_W'(1);
              if (bits_left_q == CNT_W'(1)) state_q <= ENG_TAIL;
              else shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            end
          end else begin
            half_cnt_q <= half_cnt_q + DIV_W'(1);
          end
        end
        ENG_TAIL: begin
          if (tick) begin
            state_q    <= ENG_IDLE;
            half_cnt_q <= '0;
            done       <= 1'b1;
          end else begin
            half_cnt_q <= half_cnt_q + DIV_W'(1);
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ENG_IDLE);
  assign rx_byte = rx_q;
  assign mosi_o  = (state_q == ENG_SHIFT) ? shreg_q[FRAME_W-1] : 1'b0;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_lines
    logic sel;
    assign sel       = (dev_q == DEV_W'(g)) && (state_q != ENG_IDLE);
    assign cs_n_o[g] = ~sel;
    assign sck_o[g]  = sel && sck_q && (state_q == ENG_SHIFT);
  end
endmodule

// File: rtl/dcxo_update_buf.sv
// One pending slot per port; a write replaces an unsent value.
module dcxo_update_buf #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2,
  parameter int CTRL_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [DEV_W-1:0]               in_port,
  input  logic [CTRL_W-1:0]              in_value,
  input  logic                           take,
  input  logic [DEV_W-1:0]               take_port,
  output logic [NUM_DEV-1:0]             pend,
  output logic [NUM_DEV-1:0][CTRL_W-1:0] vals
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
    logic wr_hit, take_hit;
    assign wr_hit   = in_valid && (in_port == DEV_W'(g));
    assign take_hit = take && (take_port == DEV_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= 1'b0;
        vals[g] <= '0;
      end else if (wr_hit) begin
        pend[g] <= 1'b1;
        vals[g] <= in_value;
      end else if (take_hit) begin
        pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcxo_rr_pick.sv
// Round-robin choice among pending ports, starting after the last served.
module dcxo_rr_pick #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  input  logic               advance,
  output logic               any,
  output logic [DEV_W-1:0]   pick
);
  logic [DEV_W-1:0] last_q;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_DEV; k++) begin
      int j;
      j = int'(last_q) + k;
      if (j >= NUM_DEV) j = j - NUM_DEV;
      if (!found && req[j]) begin
        pick  = DEV_W'(j);
        found = 1'b1;
      end
    end
    any = found;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= DEV_W'(NUM_DEV - 1);
    else if (advance) last_q <= pick;
  end
endmodule

// File: rtl/dcxo_spi_ctrl.sv
module dcxo_spi_ctrl
  import dcxo_spi_pkg::*;
#(
  parameter int         NUM_DEV    = 4,
  parameter int         CTRL_W     = 16,
  parameter int         WORD_BYTES = 4,
  parameter int         DIV_W      = 8,
  parameter logic [6:0] FREQ_ADDR  = 7'h10,
  parameter logic [6:0] RST_ADDR   = 7'h7F,
  parameter logic [7:0] RST_CODE   = 8'h01,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int WORD_W  = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [DEV_W-1:0]  cpu_dev,
  input  logic [6:0]        cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic [7:0]        cpu_rd_data,
  output logic              cpu_rd_done,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [DEV_W-1:0]  flt_port,
  input  logic [CTRL_W-1:0] flt_value,
  output logic [NUM_DEV-1:0] spi_sck,
  output logic [NUM_DEV-1:0] spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int FRAME_W = WORD_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] BITS_CPU  = CNT_W'(16);
  localparam logic [CNT_W-1:0] BITS_FREQ = CNT_W'(FRAME_W);
  localparam int PAD_W = FRAME_W - 16;

  cpu_op_e     req_op, p_op_q;
  logic        cpu_pend_q, cpu_fly_q, rd_fly_q, rd_done_q;
  logic [DEV_W-1:0] p_dev_q;
  logic [6:0]  p_addr_q;
  logic [7:0]  p_wdata_q, rd_data_q;
  logic [NUM_DEV-1:0][WORD_W-1:0] base_q;
  logic        cpu_accept, base_load;

  logic        eng_busy, eng_done, eng_start;
  logic [7:0]  eng_rx;
  logic [DEV_W-1:0]   start_dev;
  logic [FRAME_W-1:0] start_frame;
  logic [CNT_W-1:0]   start_bits;

  logic [NUM_DEV-1:0]             pend;
  logic [NUM_DEV-1:0][CTRL_W-1:0] vals;
  logic              rr_any, launch_cpu, launch_flt, flt_take;
  logic [DEV_W-1:0]  rr_pick;
  logic [CTRL_W-1:0] sel_val;
  logic [WORD_W-1:0] freq_word;

  assign req_op     = cpu_op_e'(cpu_op);
  assign cpu_busy   = cpu_pend_q | cpu_fly_q;
  assign cpu_accept = cpu_req && !cpu_busy && (req_op != OP_BASE);
  assign base_load  = cpu_req && (req_op == OP_BASE);
  assign flt_ready  = !rst;
  assign flt_take   = flt_valid && flt_ready;

  // Arbitration only while the wire is idle; CPU first.
  assign launch_cpu = !eng_busy && cpu_pend_q;
  assign launch_flt = !eng_busy && !cpu_pend_q && rr_any;
  assign eng_start  = launch_cpu || launch_flt;

  assign sel_val   = vals[rr_pick];
  assign freq_word = base_q[rr_pick] + {{(WORD_W-CTRL_W){sel_val[CTRL_W-1]}}, sel_val};

  always_comb begin
    start_dev   = rr_pick;
    start_bits  = BITS_FREQ;
    start_frame = {1'b0, FREQ_ADDR, freq_word};
    if (cpu_pend_q) begin
      start_dev  = p_dev_q;
      start_bits = BITS_CPU;
      case (p_op_q)
        OP_READ:  start_frame = {1'b1, p_addr_q, 8'h00, {PAD_W{1'b0}}};
        OP_RESET: start_frame = {1'b0, RST_ADDR, RST_CODE, {PAD_W{1'b0}}};
        default:  start_frame = {1'b0, p_addr_q, p_wdata_q, {PAD_W{1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_pend_q <= 1'b0;
      cpu_fly_q  <= 1'b0;
      rd_fly_q   <= 1'b0;
      rd_done_q  <= 1'b0;
      rd_data_q  <= '0;
      p_op_q     <= OP_WRITE;
      p_dev_q    <= '0;
      p_addr_q   <= '0;
      p_wdata_q  <= '0;
    end else begin
      if (cpu_accept) begin
        cpu_pend_q <= 1'b1;
        p_op_q     <= req_op;
        p_dev_q    <= cpu_dev;
        p_addr_q   <= cpu_addr;
        p_wdata_q  <= cpu_wdata[7:0];
        rd_done_q  <= 1'b0;
      end
      if (eng_done && cpu_fly_q) begin
        cpu_fly_q <= 1'b0;
        rd_fly_q  <= 1'b0;
        if (rd_fly_q) begin
          rd_data_q <= eng_rx;
          rd_done_q <= 1'b1;
        end
      end
      if (launch_cpu) begin
        cpu_pend_q <= 1'b0;
        cpu_fly_q  <= 1'b1;
        rd_fly_q   <= (p_op_q == OP_READ);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (base_load) base_q[cpu_dev] <= cpu_wdata;
  end

  assign cpu_rd_data = rd_data_q;
  assign cpu_rd_done = rd_done_q;

  dcxo_update_buf #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .CTRL_W(CTRL_W)) u_buf (
    .clk(clk), .rst(rst), .in_valid(flt_take), .in_port(flt_port),
    .in_value(flt_value), .take(launch_flt), .take_port(rr_pick),
    .pend(pend), .vals(vals)
  );

  dcxo_rr_pick #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_rr (
    .clk(clk), .rst(rst), .req(pend), .advance(launch_flt),
    .any(rr_any), .pick(rr_pick)
  );

  spi_frame_engine #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .FRAME_W(FRAME_W),
                     .CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .start_dev(start_dev),
    .start_frame(start_frame), .start_bits(start_bits), .clk_div(clk_div),
    .miso_i(spi_miso), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
    .sck_o(spi_sck), .cs_n_o(spi_cs_n), .mosi_o(spi_mosi)
  );
endmodule

// File: rtl/dcxo_spi_ctrl_chk.sv
module dcxo_spi_ctrl_chk #(
  parameter int NUM_DEV = 4,
  parameter int DIV_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [DIV_W-1:0]   clk_div,
  input logic               cpu_req,
  input logic [1:0]         cpu_op,
  input logic               cpu_busy,
  input logic               cpu_rd_done,
  input logic               flt_ready,
  input logic [NUM_DEV-1:0] spi_sck,
  input logic [NUM_DEV-1:0] spi_cs_n,
  input logic               spi_mosi
);
  logic [DIV_W:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (|spi_sck) hi_cnt <= hi_cnt + (DIV_W+1)'(1);
    else hi_cnt <= '0;
  end

  assert_one_cs_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(~spi_cs_n) <= 1);

  assert_sck_needs_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (spi_sck & spi_cs_n) == '0);

  assert_mosi_stable_at_rise_R3: assert property (@(posedge clk) disable iff (rst)
    ((|spi_sck) && !$past(|spi_sck)) |-> $stable(spi_mosi));

  assert_high_phase_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(|spi_sck) |-> (hi_cnt == ({1'b0, clk_div} + (DIV_W+1)'(1))));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_busy && cpu_op != 2'd3) |=> cpu_busy);

  assert_ready_outside_reset_R9: assert property (@(posedge clk) disable iff (rst)
    flt_ready);

  assert_done_clears_R13: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_busy && cpu_op != 2'd3) |=> !cpu_rd_done);
endmodule

bind dcxo_spi_ctrl dcxo_spi_ctrl_chk #(.NUM_DEV(NUM_DEV), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .clk_div(clk_div), .cpu_req(cpu_req), .cpu_op(cpu_op),
  .cpu_busy(cpu_busy), .cpu_rd_done(cpu_rd_done), .flt_ready(flt_ready),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/tb_dcxo_spi_ctrl.sv
module tb_dcxo_spi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div = 8'd1;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [1:0]  cpu_dev = 2'd0;
  logic [6:0]  cpu_addr = 7'd0;
  logic [31:0] cpu_wdata = 32'd0;
  logic        cpu_busy, cpu_rd_done, flt_ready, spi_mosi;
  logic [7:0]  cpu_rd_data;
  logic        flt_valid = 1'b0;
  logic [1:0]  flt_port = 2'd0;
  logic [15:0] flt_value = 16'd0;
  logic [ND-1:0] spi_sck, spi_cs_n;
  logic        spi_miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcxo_spi_ctrl dut (
    .clk(clk), .rst(rst), .clk_div(clk_div), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_dev(cpu_dev), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_rd_data(cpu_rd_data), .cpu_rd_done(cpu_rd_done),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_port(flt_port),
    .flt_value(flt_value), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Frame recorder and read-responding device model
  int          rec_n = 0;
  int          rec_dev [256];
  int          rec_bits[256];
  logic [63:0] rec_data[256];
  int          cur_bits[ND];
  logic [63:0] cur_data[ND];
  logic [6:0]  cur_addr[ND];
  logic [ND-1:0] prev_sck = '0, prev_cs = '1;
  int          hi_run = 0, phase_err = 0, phase_seen = 0, stray = 0;

  function automatic logic [7:0] dev_byte(int d, logic [6:0] a);
    return 8'(int'(a) * 3 + d * 65 + 23);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < ND; d++) begin
        if (spi_cs_n[d] && spi_sck[d]) stray++;
        if (!spi_cs_n[d] && prev_cs[d]) begin
          cur_bits[d] = 0; cur_data[d] = '0; spi_miso = 1'b0;
        end
        if (!spi_cs_n[d] && spi_sck[d] && !prev_sck[d]) begin
          cur_data[d] = {cur_data[d][62:0], spi_mosi};
          cur_bits[d]++;
          if (cur_bits[d] == 8) cur_addr[d] = cur_data[d][6:0];
        end
        if (!spi_cs_n[d] && !spi_sck[d] && prev_sck[d] &&
            cur_bits[d] >= 8 && cur_bits[d] < 16)
          spi_miso = dev_byte(d, cur_addr[d])[15 - cur_bits[d]];
        if (spi_cs_n[d] && !prev_cs[d] && rec_n < 256) begin
          rec_dev[rec_n] = d; rec_bits[rec_n] = cur_bits[d];
          rec_data[rec_n] = cur_data[d]; rec_n++;
        end
      end
      if (|spi_sck) hi_run++;
      else if (hi_run != 0) begin
        phase_seen++;
        if (hi_run != int'(clk_div) + 1) phase_err++;
        hi_run = 0;
      end
      prev_sck = spi_sck; prev_cs = spi_cs_n;
    end
  end

  // Expected frames
  int          exp_n = 0, rec_base = 0;
  int          exp_dev [64];
  int          exp_bits[64];
  logic [63:0] exp_data[64];
  logic [31:0] base_m[ND];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic expect_frame(input int d, input int bits, input logic [63:0] data);
    exp_dev[exp_n] = d; exp_bits[exp_n] = bits; exp_data[exp_n] = data; exp_n++;
  endtask

  function automatic logic [63:0] freq_frame(int d, logic [15:0] v);
    logic [31:0] w;
    w = base_m[d] + {{16{v[15]}}, v};
    return {24'd0, 1'b0, 7'h10, w};
  endfunction

  task automatic check_frames(input string tag);
    int got;
    got = rec_n - rec_base;
    check(got == exp_n, {tag, " frame count"}, 64'(got), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got; i++) begin
      check(rec_dev[rec_base+i] == exp_dev[i], {tag, "/R2 device"},
            64'(rec_dev[rec_base+i]), 64'(exp_dev[i]));
      check(rec_bits[rec_base+i] == exp_bits[i], {tag, " bit count"},
            64'(rec_bits[rec_base+i]), 64'(exp_bits[i]));
      check(rec_data[rec_base+i] == exp_data[i], {tag, " frame data"},
            rec_data[rec_base+i], exp_data[i]);
    end
    rec_base = rec_n; exp_n = 0;
  endtask

  task automatic cpu_do(input logic [1:0] op, input int d, input logic [6:0] a, input logic [31:0] wd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_dev = 2'(d); cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic flt_send(input int p, input logic [15:0] v);
    @(negedge clk);
    flt_valid = 1'b1; flt_port = 2'(p); flt_value = v;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0, guard = 0;
    while (quiet < 40 && guard < 20000) begin
      @(negedge clk); guard++;
      if (spi_cs_n == '1 && !cpu_busy) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] wd [3];
    logic [6:0] ad [3];
    logic [15:0] fv [6];
    wd = '{8'hA5, 8'h00, 8'h3C}; ad = '{7'h00, 7'h55, 7'h2A};
    fv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
    for (int d = 0; d < ND; d++) base_m[d] = 32'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n == '1 && spi_sck == '0 && !spi_mosi, "R1 lines", {56'd0, spi_cs_n, spi_sck}, 64'h0F0);
    check(!cpu_busy && !cpu_rd_done, "R1 status", {62'd0, cpu_busy, cpu_rd_done}, 64'd0);
    check(flt_ready, "R9 ready", 64'(flt_ready), 64'd1);

    // R4 writes, R7 busy
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < 3; k++) begin
        cpu_do(2'd0, d, ad[k], {24'hFFFFFF, wd[k]});
        check(cpu_busy, "R7 busy after accept", 64'(cpu_busy), 64'd1);
        expect_frame(d, 16, {48'd0, 1'b0, ad[k], wd[k]});
        wait_idle();
      end
    check_frames("R4");

    // R7 request while busy ignored
    cpu_do(2'd0, 1, 7'h11, 32'h22);
    cpu_do(2'd0, 2, 7'h33, 32'h44);
    expect_frame(1, 16, {48'd0, 8'h11, 8'h22});
    wait_idle();
    check_frames("R7");

    // R5 reads, R13 clear
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < 3; k++) begin
        cpu_do(2'd1, d, ad[k], 32'd0);
        expect_frame(d, 16, {48'd0, 1'b1, ad[k], 8'h00});
        wait_idle();
        check(cpu_rd_done, "R5 done", 64'(cpu_rd_done), 64'd1);
        check(cpu_rd_data == dev_byte(d, ad[k]), "R5 data", 64'(cpu_rd_data), 64'(dev_byte(d, ad[k])));
      end
    check_frames("R5");
    cpu_do(2'd0, 0, 7'h01, 32'h01);
    check(!cpu_rd_done, "R13 done cleared", 64'(cpu_rd_done), 64'd0);
    expect_frame(0, 16, {48'd0, 8'h01, 8'h01});
    wait_idle();
    check_frames("R13");

    // R6 device reset
    for (int d = 0; d < ND; d++) begin
      cpu_do(2'd2, d, 7'h05, 32'h0);
      expect_frame(d, 16, {48'd0, 8'h7F, 8'h01});
      wait_idle();
    end
    check_frames("R6");

    // R8 base load: no frame, no busy
    for (int d = 0; d < ND; d++) begin
      base_m[d] = 32'h1000_0000 + 32'(d) * 32'h0123_4567;
      cpu_do(2'd3, d, 7'h00, base_m[d]);
      check(!cpu_busy, "R8 no busy", 64'(cpu_busy), 64'd0);
    end
    wait_idle();
    check_frames("R8");

    // R9 filter update sweep at two divider settings
    for (int dv = 0; dv < 2; dv++) begin
      clk_div = (dv == 0) ? 8'd0 : 8'd3;
      for (int d = 0; d < ND; d++)
        for (int k = 0; k < 6; k++) begin
          flt_send(d, fv[k]);
          expect_frame(d, 40, freq_frame(d, fv[k]));
          wait_idle();
        end
      check_frames("R9");
    end
    clk_div = 8'd1;
    // R9 wrap across 2^32
    base_m[0] = 32'hFFFF_FFF0;
    cpu_do(2'd3, 0, 7'h00, base_m[0]);
    flt_send(0, 16'h0020);
    expect_frame(0, 40, freq_frame(0, 16'h0020));
    wait_idle();
    base_m[1] = 32'h0000_0000;
    cpu_do(2'd3, 1, 7'h00, base_m[1]);
    flt_send(1, 16'hFFFF);
    expect_frame(1, 40, freq_frame(1, 16'hFFFF));
    wait_idle();
    check_frames("R9 wrap");

    // R10 overwrite while wire busy
    cpu_do(2'd0, 3, 7'h44, 32'h55);
    flt_send(0, 16'h0100);
    flt_send(0, 16'h0200);
    expect_frame(3, 16, {48'd0, 8'h44, 8'h55});
    expect_frame(0, 40, freq_frame(0, 16'h0200));
    wait_idle();
    check_frames("R10");

    // R11 CPU waits for boundary, then beats pending filter port
    flt_send(1, 16'h0AAA);
    repeat (6) @(negedge clk);
    cpu_do(2'd0, 0, 7'h66, 32'h77);
    flt_send(2, 16'h0BBB);
    expect_frame(1, 40, freq_frame(1, 16'h0AAA));
    expect_frame(0, 16, {48'd0, 8'h66, 8'h77});
    expect_frame(2, 40, freq_frame(2, 16'h0BBB));
    wait_idle();
    check_frames("R11");

    // R12 round robin: last served port 1, then ports 0,3,2 pending
    flt_send(1, 16'h0011);
    expect_frame(1, 40, freq_frame(1, 16'h0011));
    wait_idle();
    cpu_do(2'd0, 3, 7'h12, 32'h34);
    flt_send(0, 16'h0C00);
    flt_send(3, 16'h0C03);
    flt_send(2, 16'h0C02);
    expect_frame(3, 16, {48'd0, 8'h12, 8'h34});
    expect_frame(2, 40, freq_frame(2, 16'h0C02));
    expect_frame(3, 40, freq_frame(3, 16'h0C03));
    expect_frame(0, 40, freq_frame(0, 16'h0C00));
    wait_idle();
    check_frames("R12");

    // R2 / R3 line-level checks accumulated by the monitor
    check(stray == 0, "R2 stray clock", 64'(stray), 64'd0);
    check(phase_err == 0 && phase_seen > 0, "R3 high phase length", 64'(phase_err), 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule